// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block keeps the 10-bit fetch address for a 1K-word program store and chooses the next address on every clock edge. The sources are a synchronous reset, two fixed interrupt vectors, a plain increment, a skip-ahead by two, a write of the low address byte, a full jump or call target, and a return address taken from a small internal stack.

Decoded instruction strobes arrive from the instruction decoder. Two level-sensitive interrupt requests are qualified by a global enable and by the free space in the return stack. The block reports the current address, a stack-full flag and a one-cycle acknowledge for each interrupt source. An accepted interrupt shows its acknowledge in the same cycle that the vector address appears on `pc`.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` becomes 000H, the stack empties, `stack_full` goes low and both acknowledges go low.
- R2: With no strobe and no accepted interrupt, `pc` advances by 1 on each edge, and 3FFH wraps to 000H.
- R3: `skip` advances `pc` by 2 modulo 1024, so 3FFH goes to 001H.
- R4: `pcl_wr` loads `pc[7:0]` from `data_byte` and keeps `pc[9:8]`.
- R5: `jump` loads all 10 bits from `target`. `call` does the same and also pushes `pc`+1 (mod 1024) onto the return stack.
- R6: `ret` loads `pc` from the most recent stack entry and removes that entry. A `ret` on an empty stack loads 000H and leaves the stack empty.
- R7: An accepted external interrupt loads 004H, pushes `pc`+1 and raises `ack_ext` for exactly the next cycle.
- R8: An accepted timer interrupt loads 008H, pushes `pc`+1 and raises `ack_tmr` for exactly the next cycle.
- R9: An interrupt is accepted only when `irq_en` is high and `stack_full` is low. When both requests are present, the external one wins and the timer request waits.
- R10: `stack_full` is high exactly when 4 entries are held. A push into a full stack is discarded, and the stack keeps its contents and count.
- R11: Precedence in one cycle: accepted interrupt, then `ret`, then `call`, then `jump`, then `pcl_wr`, then `skip`, then increment. A strobe that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 1 | External interrupt request, level |
| tmr_req | input | 1 | Timer overflow interrupt request, level |
| irq_en | input | 1 | Global interrupt enable |
| skip | input | 1 | Skip the next instruction |
| pcl_wr | input | 1 | Write the low address byte |
| jump | input | 1 | Load the target, no push |
| call | input | 1 | Load the target and push the return address |
| ret | input | 1 | Pop the return address into the PC |
| target | input | 10 | Address field of the instruction |
| data_byte | input | 8 | Data for a low-byte write |
| pc | output | 10 | Current fetch address |
| stack_full | output | 1 | Return stack holds 4 entries |
| ack_ext | output | 1 | External interrupt taken (one cycle) |
| ack_tmr | output | 1 | Timer interrupt taken (one cycle) |

## Verification
Directed sequences start each address source at the edges of the address space. Increment and skip are applied from 3FFH to separate correct wrap from carry into a missing bit, and a low-byte write is made on a non-zero page to show that the page bits are kept. Calls nested to depth four followed by pending interrupts show whether the full flag blocks acceptance, and a fifth call shows that a push into a full stack is discarded. Returns on an emptied stack check the defined 000H result. Long runs of random strobe and request patterns, in which several strobes often overlap, test the precedence order and the stack contents against a reference model in the bench.

// File: rtl/pcs_pkg.sv
// Package: shared constants and types for the program counter sequencer.
// Assumes a 10-bit address space and fixed interrupt vectors.
package pcs_pkg;
    localparam int unsigned PC_W   = 10;
    localparam int unsigned BYTE_W = 8;

    localparam logic [PC_W-1:0] VEC_RESET = 10'h000;
    localparam logic [PC_W-1:0] VEC_EXT   = 10'h004;
    localparam logic [PC_W-1:0] VEC_TMR   = 10'h008;

    // Which source supplies the next fetch address
    typedef enum logic [2:0] {
        SRC_INC,
        SRC_SKIP,
        SRC_LOW,
        SRC_JUMP,
        SRC_CALL,
        SRC_RET,
        SRC_VEXT,
        SRC_VTMR
    } pc_src_e;
endpackage

// File: rtl/pcs_irq_arb.sv
// Interrupt arbiter: decides whether a pending request is taken this cycle.
// Assumes level requests that the requester holds until it sees the acknowledge.
// The external source has priority. Nothing is taken while the stack is full.
module pcs_irq_arb (
    input  logic ext_req,
    input  logic tmr_req,
    input  logic irq_en,
    input  logic stack_full,
    output logic take_ext,
    output logic take_tmr
);
    logic open_gate;

    // Gate requests with the enable and the stack space, then rank them
    always_comb begin
        open_gate = irq_en && !stack_full;
        take_ext  = open_gate && ext_req;
        take_tmr  = open_gate && tmr_req && !ext_req;
    end
endmodule

// File: rtl/pcs_ret_stack.sv
// Return-address stack with a fill count and no wrap.
// Assumes push and pop are never high together (the next-address logic ensures this).
// A push while full is dropped. A pop while empty does nothing and reads zero.
module pcs_ret_stack #(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] top_val,
    output logic             full
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0] fill_q;
    logic             empty;

    // Derive the flags and the read-out of the most recent entry
    always_comb begin
        full    = (fill_q == CNT_W'(DEPTH));
        empty   = (fill_q == '0);
        top_val = empty ? '0 : slot_q[IDX_W'(fill_q - 1'b1)];
    end

    // Update the entries and the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
        end else if (push && !full) begin
            slot_q[IDX_W'(fill_q)] <= push_val;
            fill_q <= fill_q + 1'b1;
        end else if (pop && !empty) begin
            fill_q <= fill_q - 1'b1;
        end
    end

    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));
    assert_full_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> full && $stable(top_val));
    assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> !full);
endmodule

// File: rtl/pcs_next_sel.sv
// Next-address selector: ranks the decoded strobes and the accepted interrupts.
// Assumes at most one interrupt acceptance per cycle (arbiter output).
// Order: interrupt, return, call, jump, low-byte write, skip, increment.
module pcs_next_sel
    import pcs_pkg::*;
(
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              take_ext,
    input  logic              take_tmr,
    input  logic              ret,
    input  logic              call,
    input  logic              jump,
    input  logic              pcl_wr,
    input  logic              skip,
    input  logic [PC_W-1:0]   target,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [PC_W-1:0]   stack_top,
    output logic [PC_W-1:0]   pc_next,
    output logic [PC_W-1:0]   link_addr,
    output logic              push,
    output logic              pop
);
    pc_src_e src;

    // Pick the winning source by fixed precedence
    always_comb begin
        if (take_ext)      src = SRC_VEXT;
        else if (take_tmr) src = SRC_VTMR;
        else if (ret)      src = SRC_RET;
        else if (call)     src = SRC_CALL;
        else if (jump)     src = SRC_JUMP;
        else if (pcl_wr)   src = SRC_LOW;
        else if (skip)     src = SRC_SKIP;
        else               src = SRC_INC;
    end

    // Form the next address and the stack controls from the winner
    always_comb begin
        link_addr = pc_cur + 1'b1;
        push      = (src == SRC_VEXT) || (src == SRC_VTMR) || (src == SRC_CALL);
        pop       = (src == SRC_RET);
        case (src)
            SRC_VEXT: pc_next = VEC_EXT;
            SRC_VTMR: pc_next = VEC_TMR;
            SRC_RET:  pc_next = stack_top;
            SRC_CALL: pc_next = target;
            SRC_JUMP: pc_next = target;
            SRC_LOW:  pc_next = {pc_cur[PC_W-1:BYTE_W], data_byte};
            SRC_SKIP: pc_next = pc_cur + 2'd2;
            default:  pc_next = pc_cur + 1'b1;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Program counter sequencer: holds the fetch address and moves it each cycle.
// Assumes decoded strobes that are valid for one cycle and level interrupt
// requests. Contains the return stack. The acknowledge is registered with the PC.
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int unsigned STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic              tmr_req,
    input  logic              irq_en,
    input  logic              skip,
    input  logic              pcl_wr,
    input  logic              jump,
    input  logic              call,
    input  logic              ret,
    input  logic [PC_W-1:0]   target,
    input  logic [BYTE_W-1:0] data_byte,
    output logic [PC_W-1:0]   pc,
    output logic              stack_full,
    output logic              ack_ext,
    output logic              ack_tmr
);
    logic [PC_W-1:0] pc_q, pc_next, link_addr, stack_top;
    logic            take_ext, take_tmr, push, pop, full_w;
    logic            ack_ext_q, ack_tmr_q;

    pcs_irq_arb i_arb (
        .ext_req    (ext_req),
        .tmr_req    (tmr_req),
        .irq_en     (irq_en),
        .stack_full (full_w),
        .take_ext   (take_ext),
        .take_tmr   (take_tmr)
    );

    pcs_next_sel i_sel (
        .pc_cur    (pc_q),
        .take_ext  (take_ext),
        .take_tmr  (take_tmr),
        .ret       (ret),
        .call      (call),
        .jump      (jump),
        .pcl_wr    (pcl_wr),
        .skip      (skip),
        .target    (target),
        .data_byte (data_byte),
        .stack_top (stack_top),
        .pc_next   (pc_next),
        .link_addr (link_addr),
        .push      (push),
        .pop       (pop)
    );

    pcs_ret_stack #(.WIDTH(PC_W), .DEPTH(STACK_DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (link_addr),
        .top_val  (stack_top),
        .full     (full_w)
    );

    // Register the fetch address and the acknowledge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= VEC_RESET;
            ack_ext_q <= 1'b0;
            ack_tmr_q <= 1'b0;
        end else begin
            pc_q      <= pc_next;
            ack_ext_q <= take_ext;
            ack_tmr_q <= take_tmr;
        end
    end

    // Drive the outputs
    always_comb begin
        pc         = pc_q;
        stack_full = full_w;
        ack_ext    = ack_ext_q;
        ack_tmr    = ack_tmr_q;
    end

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == VEC_RESET) && !ack_ext && !ack_tmr && !stack_full);
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req && !tmr_req && !skip && !pcl_wr && !jump && !call && !ret)
        |=> pc == $past(pc) + 10'd1);
    assert_skip_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req && !tmr_req && skip && !pcl_wr && !jump && !call && !ret)
        |=> pc == $past(pc) + 10'd2);
    assert_low_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req && !tmr_req && pcl_wr && !jump && !call && !ret)
        |=> pc[PC_W-1:BYTE_W] == $past(pc[PC_W-1:BYTE_W]));
    assert_ext_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ext |-> pc == VEC_EXT);
    assert_tmr_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tmr |-> pc == VEC_TMR);
    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_ext, ack_tmr}));
    assert_no_take_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_full || !irq_en) |=> !ack_ext && !ack_tmr);
    assert_push_pop_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: tb/test_pc_sequencer.sv
// Bench for pc_sequencer: directed corners and seeded random strobes,
// compared each cycle with a reference model kept in the bench.
module test_pc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req = 0, tmr_req = 0, irq_en = 0;
    logic       skip = 0, pcl_wr = 0, jump = 0, call = 0, ret = 0;
    logic [9:0] target = '0;
    logic [7:0] data_byte = '0;
    logic [9:0] pc;
    logic       stack_full, ack_ext, ack_tmr;

    int checks = 0;
    int fails  = 0;

    logic [9:0] m_pc;
    logic [9:0] m_stk [4];
    int         m_cnt;
    logic       m_ae, m_at;

    always #2.5 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .tmr_req(tmr_req),
        .irq_en(irq_en), .skip(skip), .pcl_wr(pcl_wr), .jump(jump),
        .call(call), .ret(ret), .target(target), .data_byte(data_byte),
        .pc(pc), .stack_full(stack_full), .ack_ext(ack_ext), .ack_tmr(ack_tmr)
    );

    function automatic void m_push(logic [9:0] v);
        if (m_cnt < 4) begin
            m_stk[m_cnt] = v;
            m_cnt++;
        end
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare(string req);
        chk(pc == m_pc, req, int'(pc), int'(m_pc));
        chk(stack_full == (m_cnt == 4), {req, " R10 full"}, int'(stack_full), int'(m_cnt == 4));
        chk(ack_ext == m_ae, {req, " R7 ack_ext"}, int'(ack_ext), int'(m_ae));
        chk(ack_tmr == m_at, {req, " R8 ack_tmr"}, int'(ack_tmr), int'(m_at));
    endtask

    // Apply one cycle of inputs at the falling edge, model it, then compare
    task automatic step(bit e, bit t, bit en, bit sk, bit pw, bit j, bit c, bit r,
                        logic [9:0] tg, logic [7:0] db, string req);
        bit acc_e, acc_t;
        ext_req = e; tmr_req = t; irq_en = en; skip = sk; pcl_wr = pw;
        jump = j; call = c; ret = r; target = tg; data_byte = db;
        acc_e = en && (m_cnt < 4) && e;
        acc_t = en && (m_cnt < 4) && t && !e;
        if (acc_e) begin m_push(m_pc + 10'd1); m_pc = 10'h004; end
        else if (acc_t) begin m_push(m_pc + 10'd1); m_pc = 10'h008; end
        else if (r) begin
            if (m_cnt > 0) begin m_cnt--; m_pc = m_stk[m_cnt]; end
            else m_pc = 10'h000;
        end
        else if (c) begin m_push(m_pc + 10'd1); m_pc = tg; end
        else if (j) m_pc = tg;
        else if (pw) m_pc = {m_pc[9:8], db};
        else if (sk) m_pc = m_pc + 10'd2;
        else m_pc = m_pc + 10'd1;
        m_ae = acc_e; m_at = acc_t;
        @(posedge clk); @(negedge clk);
        compare(req);
    endtask

    task automatic idle(string req);
        step(0,0,0,0,0,0,0,0,'0,'0,req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        @(posedge clk); @(negedge clk);
        m_pc = '0; m_cnt = 0; m_ae = 0; m_at = 0;
        compare("R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic idle_inputs();
        ext_req = 0; tmr_req = 0; irq_en = 0; skip = 0; pcl_wr = 0;
        jump = 0; call = 0; ret = 0; target = '0; data_byte = '0;
    endtask

    initial begin
        #(5 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_pc = '0; m_cnt = 0; m_ae = 0; m_at = 0;
        @(negedge clk);
        do_reset();
        // R2 increment and wrap
        idle("R2 inc");
        step(0,0,0,0,0,1,0,0,10'h3FF,'0,"R5 jump to 3FF");
        idle("R2 wrap 3FF->000");
        // R3 skip wrap
        step(0,0,0,0,0,1,0,0,10'h3FF,'0,"R5 jump");
        step(0,0,0,1,0,0,0,0,'0,'0,"R3 skip wrap 3FF->001");
        // R4 low-byte write on page 2
        step(0,0,0,0,0,1,0,0,10'h2F0,'0,"R5 jump page2");
        step(0,0,0,0,1,0,0,0,'0,8'h5A,"R4 low byte keeps page");
        // R6 return on empty stack
        step(0,0,0,0,0,0,0,1,'0,'0,"R6 ret empty");
        // R10 fill stack with calls, fifth dropped
        for (int i = 0; i < 5; i++)
            step(0,0,0,0,0,0,1,0,10'(10'h100 + 16*i),'0,"R5 R10 call nest");
        // R9 interrupts blocked while full
        step(1,1,1,0,0,0,0,0,'0,'0,"R9 blocked when full");
        // R6 unwind
        for (int i = 0; i < 5; i++) step(0,0,0,0,0,0,0,1,'0,'0,"R6 ret unwind");
        // R9 enable gate, then ext priority
        step(1,0,0,0,0,0,0,0,'0,'0,"R9 disabled");
        step(1,1,1,0,0,0,0,0,'0,'0,"R9 ext wins");
        step(0,1,1,0,0,0,0,0,'0,'0,"R8 timer taken");
        idle("R7 ack one cycle");
        // R11 precedence overlaps
        step(1,0,1,1,1,1,1,1,10'h123,8'h77,"R11 irq over all");
        step(0,0,0,1,1,1,1,1,10'h123,8'h77,"R11 ret over call");
        step(0,0,0,1,1,1,1,0,10'h155,8'h77,"R11 call over jump");
        step(0,0,0,1,1,1,0,0,10'h0AA,8'h77,"R11 jump over low");
        step(0,0,0,1,1,0,0,0,'0,8'h33,"R11 low over skip");
        // mid-run reset
        do_reset();
        // seeded random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] == 0, r[7:4] == 0, r[8], r[11:9] == 0, r[14:12] == 0,
                 r[17:15] == 0, r[20:18] == 0, r[23:21] < 2,
                 10'($urandom), 8'($urandom), "R11 random mix");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule